// File: doc/BRIEF.md
# Per-Pin Configurable I/O Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port that sits on a small register bus. Software picks the role of each pin independently. A pin can be a plain input, an output driven from a software-written value, or it can be handed over to an alternate peripheral. In the last case the peripheral's drive value and drive enable reach the pad instead of the port's own.

Every pin level passes through a two-flop synchroniser. The synchronised level feeds three things: the readable input register, the alternate peripheral's input, and a per-pin transition detector. Each pin chooses whether a rising or a falling transition is of interest. A matching transition sets a sticky per-pin pending flag, and software can write that flag directly. A single interrupt request is raised while any pending flag has its enable bit set.

Register selection uses a 3-bit address. Writes take effect on the rising clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `pin_port`

## Requirements
- R1: Address 0 reads the synchronised level of every pin; a write to address 0 changes no register and no output.
- R2: With the select bit (address 3) at 0, a direction bit (address 2) of 0 leaves the pin undriven (pad_oe low); a 1 drives pad_out from the matching output-register bit (address 1).
- R3: With the select bit at 1, pad_out and pad_oe of that pin follow alt_out and alt_oe, whatever the direction and output registers hold; alt_in always carries the synchronised pin levels.
- R4: A pending flag is set by a transition only; a pin held at a steady level, high or low, never sets it.
- R5: A polarity bit (address 4) of 0 makes a low-to-high transition set the flag; a 1 makes a high-to-low transition set it, and the opposite transition is ignored.
- R6: A pin level present at clock edge k is readable at address 0 after edge k+1, and a transition it completes sets the flag at edge k+2.
- R7: irq is high exactly while some pin has both its pending flag (address 6) and its enable bit (address 5) at 1.
- R8: Writing address 6 loads the flags: a 0 bit clears a flag and a 1 bit sets it, so an interrupt can be raised from software.
- R9: When a hardware transition and a software write of 0 hit the same flag on the same edge, the flag ends up set.
- R10: After reset all registers read 0, every pin is an undriven input, and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Value driven onto each pin |
| pad_oe | output | 8 | Per-pin drive enable |
| alt_out | input | 8 | Alternate peripheral drive values |
| alt_oe | input | 8 | Alternate peripheral drive enables |
| alt_in | output | 8 | Synchronised pin levels for the peripheral |
| irq | output | 1 | Combined port interrupt request |

## Verification
The assertions assume that bus_we, bus_addr and bus_wdata are stable around each rising edge. They also assume that pad_in does not need more than the synchroniser to settle, so a pin level counts as seen once it has passed both flops. The bench meets these assumptions by changing every input on the falling clock edge only. After each pin change it waits several cycles before judging a flag. The one exception is the collision case, where the clear is placed on the exact edge that the transition reaches the flag.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_DRIVE = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_ALT   = 3'd3,
    SEL_POL   = 3'd4,
    SEL_ENA   = 3'd5,
    SEL_PEND  = 3'd6
  } reg_sel_e;

  // Transition of interest for one pin: pol=0 rising, pol=1 falling.
  function automatic logic edge_seen(input logic now_lvl, input logic was_lvl,
                                     input logic pol);
    if (pol) return was_lvl & ~now_lvl;
    return now_lvl & ~was_lvl;
  endfunction

  // Next flag value: hardware hit always wins over a software load.
  function automatic logic pend_next(input logic cur, input logic hit,
                                     input logic load, input logic load_bit);
    if (load) return load_bit | hit;
    return cur | hit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/pin_edge.sv
module pin_edge
  import pin_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] was_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_q <= '0;
    else        was_q <= level;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign hit[b] = edge_seen(level[b], was_q[b], pol[b]);
  end
endmodule

// File: rtl/pin_route.sv
module pin_route #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] use_alt,
  input  logic [WIDTH-1:0] drive_val,
  input  logic [WIDTH-1:0] drive_en,
  input  logic [WIDTH-1:0] alt_val,
  input  logic [WIDTH-1:0] alt_en,
  output logic [WIDTH-1:0] pad_val,
  output logic [WIDTH-1:0] pad_en
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    assign pad_val[b] = use_alt[b] ? alt_val[b] : drive_val[b];
    assign pad_en[b]  = use_alt[b] ? alt_en[b]  : drive_en[b];
  end
endmodule

// File: rtl/pin_port.sv
module pin_port
  import pin_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  alt_oe,
  output logic [WIDTH-1:0]  alt_in,
  output logic              irq
);
  logic [WIDTH-1:0] drive_q, dir_q, alt_q, pol_q, ena_q, pend_q;
  logic [WIDTH-1:0] level, hit, pend_d;
  logic             pend_wr;

  pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(level));

  pin_edge #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .pol(pol_q), .hit(hit));

  pin_route #(.WIDTH(WIDTH)) u_route (
    .use_alt(alt_q), .drive_val(drive_q), .drive_en(dir_q),
    .alt_val(alt_out), .alt_en(alt_oe), .pad_val(pad_out), .pad_en(pad_oe));

  assign alt_in  = level;
  assign pend_wr = bus_we && (bus_addr == SEL_PEND);

  for (genvar b = 0; b < WIDTH; b++) begin : g_pend
    assign pend_d[b] = pend_next(pend_q[b], hit[b], pend_wr, bus_wdata[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
      alt_q   <= '0;
      pol_q   <= '0;
      ena_q   <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (bus_we) begin
        case (reg_sel_e'(bus_addr))
          SEL_DRIVE: drive_q <= bus_wdata;
          SEL_DIR:   dir_q   <= bus_wdata;
          SEL_ALT:   alt_q   <= bus_wdata;
          SEL_POL:   pol_q   <= bus_wdata;
          SEL_ENA:   ena_q   <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_LEVEL: bus_rdata = level;
      SEL_DRIVE: bus_rdata = drive_q;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_ALT:   bus_rdata = alt_q;
      SEL_POL:   bus_rdata = pol_q;
      SEL_ENA:   bus_rdata = ena_q;
      SEL_PEND:  bus_rdata = pend_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = |(pend_q & ena_q);
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pend_wr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] hit,
  input logic [WIDTH-1:0] pend_q,
  input logic [WIDTH-1:0] ena_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] alt_q,
  input logic [WIDTH-1:0] pad_oe,
  input logic             irq
);
  // R4: no write and no transition -> flags unchanged
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && hit == '0) |=> pend_q == $past(pend_q));

  // R8: a write with no transition loads exactly the written value
  a_r8_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && hit == '0) |=> pend_q == $past(wdata));

  // R9: every bit hit by a transition is set, even under a clearing write
  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (pend_q & $past(hit)) == $past(hit));

  // R7: no interrupt without an enabled pending flag
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0 || pend_q == '0) |-> !irq);

  // R2: pins owned by the port drive only when set to output
  a_r2_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~alt_q) == '0);
endmodule

bind pin_port pin_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_wr(pend_wr), .wdata(bus_wdata),
  .hit(hit), .pend_q(pend_q), .ena_q(ena_q), .dir_q(dir_q), .alt_q(alt_q),
  .pad_oe(pad_oe), .irq(irq));

// File: tb/test_pin_port.sv
module test_pin_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, alt_in;
  logic [7:0] alt_out = '0, alt_oe = '0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_port i_pin_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 1; a < 7; a++) begin
      rd(3'(a), v);
      chk("R10 register reset", v, 8'h00);
    end
    chk("R10 pads undriven", pad_oe, 8'h00);
    chk("R10 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_direction;
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'h0F);
    @(negedge clk);
    chk("R2 drive enable", pad_oe, 8'h0F);
    chk("R2 driven values", pad_out & pad_oe, 8'h05);
  endtask

  task automatic t_alternate;
    alt_out = 8'h3C; alt_oe = 8'hF0;
    wr(3'd3, 8'hF0);
    @(negedge clk);
    chk("R3 alt values", pad_out, 8'h35);
    chk("R3 alt enables", pad_oe, 8'hFF);
    set_pins(8'h81);
    chk("R3 alt_in level", alt_in, 8'h81);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_level_read;
    logic [7:0] v;
    set_pins(8'h00);
    wr(3'd6, 8'h00);
    @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);          // edge k passed
    rd(3'd0, v);
    chk("R6 not yet visible", v, 8'h00);
    @(negedge clk);          // edge k+1 passed
    rd(3'd0, v);
    chk("R6 level after two edges", v, 8'h5A);
    rd(3'd6, v);
    chk("R6 flag not before k+2", v, 8'h00);
    @(negedge clk);
    rd(3'd6, v);
    chk("R6 flag at k+2", v, 8'h5A);
    wr(3'd0, 8'hFF);
    rd(3'd0, v);
    chk("R1 input write ignored", v, 8'h5A);
    chk("R1 outputs untouched", pad_out & pad_oe, 8'h05);
    rd(3'd1, v);
    chk("R1 output reg untouched", v, 8'hA5);
  endtask

  task automatic t_polarity;
    logic [7:0] v;
    set_pins(8'hF0);
    wr(3'd4, 8'hF0);         // upper nibble falling, lower rising
    wr(3'd6, 8'h00);
    set_pins(8'h0F);
    rd(3'd6, v);
    chk("R5 fall upper, rise lower", v, 8'hFF);
    wr(3'd6, 8'h00);
    set_pins(8'hF0);
    rd(3'd6, v);
    chk("R5 opposite transitions ignored", v, 8'h00);
    repeat (10) @(negedge clk);
    rd(3'd6, v);
    chk("R4 steady level sets nothing", v, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_soft_flag;
    logic [7:0] v;
    wr(3'd6, 8'h24);
    rd(3'd6, v);
    chk("R8 software set", v, 8'h24);
    chk("R7 irq off without enable", {7'd0, irq}, 8'h00);
    wr(3'd5, 8'h04);
    chk("R7 irq on with enable", {7'd0, irq}, 8'h01);
    wr(3'd6, 8'h20);
    rd(3'd6, v);
    chk("R8 software clear", v, 8'h20);
    chk("R7 irq off after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    set_pins(8'h00);
    wr(3'd6, 8'h20);
    @(negedge clk);
    pad_in = 8'h01;          // edge k samples it
    @(negedge clk);
    @(negedge clk);          // k+1 passed, transition reaches flag at k+2
    bus_addr = 3'd6; bus_wdata = 8'h00; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd6, v);
    chk("R9 edge beats clear", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_alternate();
    t_level_read();
    t_polarity();
    t_soft_flag();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule